// File: doc/BRIEF.md
# Learning Bridge Forwarding Engine

This block makes the forwarding decision for a small multi-port learning bridge. For every received frame it takes the destination address, the source address and the ingress port number. It answers with a bitmap of egress ports and a drop flag. A destination that the bridge has learned goes to exactly one port. An unknown destination, or a group (multicast or broadcast) destination, is flooded to every port except the ingress port. A frame whose learned destination lives on its own ingress port is discarded. The frame buffer manager then returns that buffer to its free pool.

In the same frame slot the engine learns the source address. It writes a new entry, or updates the port of an existing one, in an on-chip table. The table has 2**IDX_W buckets of two ways each. The bucket is chosen by folding the address, after an XOR with a programmable salt. Software can pick the salt so that a known set of stations spreads across buckets with few collisions. The engine accepts one request every clock and answers each one exactly two cycles later, in order.

Top module: `fwd_engine`

## Requirements
- R1: `req_ready` is low during reset and high from the first clock edge after reset is released. A request is accepted on each edge where `req_valid` and `req_ready` are both high. Its response has `rsp_valid` high in the cycle two cycles after the request cycle, with exactly one response per accepted request, in order. When `rsp_valid` is low, `rsp_ports` is zero and `rsp_drop` is low.
- R2: If the destination is found in the table on a port other than the ingress port, `rsp_ports` has only that port's bit set (bit n means port n) and `rsp_drop` is low.
- R3: If a non-group destination is not in the table, `rsp_ports` has every bit set except the ingress port's bit, and `rsp_drop` is low.
- R4: If the destination is found on the ingress port itself, `rsp_drop` is high and `rsp_ports` is zero.
- R5: A destination with bit 40 set is flooded as in R3, whatever the table holds. Bit 40 is the least significant bit of the most significant octet of the 48-bit address.
- R6: Each accepted frame whose source has bit 40 clear learns that source on the ingress port. A later frame to that address follows R2 or R4, and the next frame already sees the result. A source that is already present keeps its way and only has its port replaced.
- R7: A source with bit 40 set is never written into the table, so it cannot evict a learned entry.
- R8: Bucket index bit i is the XOR of all bits j of (address XOR `hash_salt`) with j mod IDX_W equal to i. Each bucket holds two entries. A new address in a full bucket replaces the entry that was inserted earlier, and a port update does not change that insertion order.
- R9: When a frame's destination equals its own source, the lookup uses the table content from before that frame's learning write.
- R10: Reset empties the table, so every lookup after reset misses until addresses are learned again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_salt | input | 48 | Salt XORed into addresses before bucket folding |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request |
| req_dst | input | 48 | Destination address of the frame |
| req_src | input | 48 | Source address of the frame |
| req_port | input | PORT_W | Ingress port number |
| rsp_valid | output | 1 | Response present |
| rsp_ports | output | NUM_PORTS | Egress port bitmap |
| rsp_drop | output | 1 | Frame is discarded |

## Verification
The hardest situation to reach from the ports is a full bucket. Three or more learned stations must fold to the same index under the current salt. Only then do eviction order, refresh order and the refusal to learn group sources show up. The bench searches random addresses with its own fold function until it finds colliding unicast and group addresses for one chosen bucket. It learns them in a fixed order and then probes each one, so an entry that was evicted appears as a flood in place of a single port. A random phase then sends traffic drawn from a small pool that is crowded into one bucket, with back-to-back frames, against a reference table kept in the bench.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
    localparam int MAC_W     = 48;
    localparam int NWAYS     = 2;
    localparam int GROUP_BIT = 40;

    function automatic logic is_group(input logic [MAC_W-1:0] addr);
        return addr[GROUP_BIT];
    endfunction
endpackage

// File: rtl/fwd_hash.sv
`timescale 1ns/1ps
module fwd_hash #(
    parameter int IDX_W = 4
) (
    input  logic [fwd_pkg::MAC_W-1:0] mac,
    input  logic [fwd_pkg::MAC_W-1:0] salt,
    output logic [IDX_W-1:0]          idx
);
    import fwd_pkg::*;

    function automatic logic [MAC_W-1:0] lane_mask(input int lane);
        logic [MAC_W-1:0] m;
        m = '0;
        for (int j = 0; j < MAC_W; j++) begin
            m[j] = ((j % IDX_W) == lane);
        end
        return m;
    endfunction

    logic [MAC_W-1:0] mixed;
    assign mixed = mac ^ salt;

    for (genvar i = 0; i < IDX_W; i++) begin : g_lane
        localparam logic [MAC_W-1:0] LMASK = lane_mask(i);
        assign idx[i] = ^(mixed & LMASK);
    end
endmodule

// File: rtl/fwd_table.sv
`timescale 1ns/1ps
module fwd_table #(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 4,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int NB       = 1 << IDX_W
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [IDX_W-1:0]                             rd_idx,
    output logic [fwd_pkg::NWAYS-1:0]                    rd_vld,
    output logic [fwd_pkg::NWAYS-1:0][fwd_pkg::MAC_W-1:0] rd_mac,
    output logic [fwd_pkg::NWAYS-1:0][PORT_W-1:0]        rd_port,
    input  logic                                         lrn_en,
    input  logic [IDX_W-1:0]                             lrn_idx,
    input  logic [fwd_pkg::MAC_W-1:0]                    lrn_mac,
    input  logic [PORT_W-1:0]                            lrn_port
);
    import fwd_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [PORT_W-1:0] port;
        logic [MAC_W-1:0]  mac;
    } ent_t;

    typedef struct packed {
        ent_t [NWAYS-1:0] way;
        logic             last;   // way written by the latest insertion
    } bkt_t;

    typedef struct packed {
        bkt_t [NB-1:0] bkt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    bkt_t lrn_bkt;
    logic [NWAYS-1:0] lrn_hit;

    assign lrn_bkt = tbl_q.bkt[lrn_idx];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign rd_vld[w]  = tbl_q.bkt[rd_idx].way[w].vld;
        assign rd_mac[w]  = tbl_q.bkt[rd_idx].way[w].mac;
        assign rd_port[w] = tbl_q.bkt[rd_idx].way[w].port;
        assign lrn_hit[w] = lrn_bkt.way[w].vld && (lrn_bkt.way[w].mac == lrn_mac);
    end

    always_comb begin
        bkt_t cur;
        logic victim;
        tbl_d  = tbl_q;
        cur    = lrn_bkt;
        victim = 1'b0;
        if (lrn_en) begin
            if (|lrn_hit) begin
                for (int w = 0; w < NWAYS; w++) begin
                    if (lrn_hit[w]) begin
                        cur.way[w].port = lrn_port;
                    end
                end
            end else begin
                if (!cur.way[0].vld) begin
                    victim = 1'b0;
                end else if (!cur.way[1].vld) begin
                    victim = 1'b1;
                end else begin
                    victim = ~cur.last;
                end
                cur.way[victim].vld  = 1'b1;
                cur.way[victim].port = lrn_port;
                cur.way[victim].mac  = lrn_mac;
                cur.last             = victim;
            end
            tbl_d.bkt[lrn_idx] = cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end
endmodule

// File: rtl/fwd_decide.sv
`timescale 1ns/1ps
module fwd_decide #(
    parameter int NUM_PORTS = 4,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic [fwd_pkg::MAC_W-1:0]                    dst,
    input  logic [PORT_W-1:0]                            ingress,
    input  logic [fwd_pkg::NWAYS-1:0]                    rd_vld,
    input  logic [fwd_pkg::NWAYS-1:0][fwd_pkg::MAC_W-1:0] rd_mac,
    input  logic [fwd_pkg::NWAYS-1:0][PORT_W-1:0]        rd_port,
    output logic [NUM_PORTS-1:0]                         ports,
    output logic                                         drop
);
    import fwd_pkg::*;

    logic [NWAYS-1:0] match;

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign match[w] = rd_vld[w] && (rd_mac[w] == dst);
    end

    always_comb begin
        logic              hit;
        logic [PORT_W-1:0] egress;
        logic [NUM_PORTS-1:0] flood;
        hit    = 1'b0;
        egress = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (match[w]) begin
                hit    = 1'b1;
                egress = rd_port[w];
            end
        end
        flood          = '1;
        flood[ingress] = 1'b0;
        ports          = '0;
        drop           = 1'b0;
        if (is_group(dst) || !hit) begin
            ports = flood;
        end else if (egress == ingress) begin
            drop = 1'b1;
        end else begin
            ports[egress] = 1'b1;
        end
    end
endmodule

// File: rtl/fwd_engine.sv
`timescale 1ns/1ps
module fwd_engine #(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 4,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [47:0]               hash_salt,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [47:0]               req_dst,
    input  logic [47:0]               req_src,
    input  logic [PORT_W-1:0]         req_port,
    output logic                      rsp_valid,
    output logic [NUM_PORTS-1:0]      rsp_ports,
    output logic                      rsp_drop
);
    import fwd_pkg::*;

    typedef struct packed {
        logic                 rdy;
        logic                 s1_vld;
        logic [MAC_W-1:0]     s1_dst;
        logic [MAC_W-1:0]     s1_src;
        logic [PORT_W-1:0]    s1_port;
        logic                 rsp_vld;
        logic [NUM_PORTS-1:0] rsp_ports;
        logic                 rsp_drop;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [IDX_W-1:0]              dst_idx, src_idx;
    logic [NWAYS-1:0]              rd_vld;
    logic [NWAYS-1:0][MAC_W-1:0]   rd_mac;
    logic [NWAYS-1:0][PORT_W-1:0]  rd_port;
    logic [NUM_PORTS-1:0]          dec_ports;
    logic                          dec_drop;
    logic                          lrn_en;

    fwd_hash #(.IDX_W(IDX_W)) u_hash_dst (
        .mac (pipe_q.s1_dst),
        .salt(hash_salt),
        .idx (dst_idx)
    );

    fwd_hash #(.IDX_W(IDX_W)) u_hash_src (
        .mac (pipe_q.s1_src),
        .salt(hash_salt),
        .idx (src_idx)
    );

    assign lrn_en = pipe_q.s1_vld && !is_group(pipe_q.s1_src);

    fwd_table #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (dst_idx),
        .rd_vld  (rd_vld),
        .rd_mac  (rd_mac),
        .rd_port (rd_port),
        .lrn_en  (lrn_en),
        .lrn_idx (src_idx),
        .lrn_mac (pipe_q.s1_src),
        .lrn_port(pipe_q.s1_port)
    );

    fwd_decide #(.NUM_PORTS(NUM_PORTS)) u_decide (
        .dst    (pipe_q.s1_dst),
        .ingress(pipe_q.s1_port),
        .rd_vld (rd_vld),
        .rd_mac (rd_mac),
        .rd_port(rd_port),
        .ports  (dec_ports),
        .drop   (dec_drop)
    );

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.rdy    = 1'b1;
        pipe_d.s1_vld = req_valid && pipe_q.rdy;
        if (req_valid && pipe_q.rdy) begin
            pipe_d.s1_dst  = req_dst;
            pipe_d.s1_src  = req_src;
            pipe_d.s1_port = req_port;
        end
        pipe_d.rsp_vld   = pipe_q.s1_vld;
        pipe_d.rsp_ports = pipe_q.s1_vld ? dec_ports : '0;
        pipe_d.rsp_drop  = pipe_q.s1_vld && dec_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign req_ready = pipe_q.rdy;
    assign rsp_valid = pipe_q.rsp_vld;
    assign rsp_ports = pipe_q.rsp_ports;
    assign rsp_drop  = pipe_q.rsp_drop;
endmodule

// File: rtl/fwd_engine_chk.sv
`timescale 1ns/1ps
module fwd_engine_chk #(
    parameter int NUM_PORTS = 4,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_dst_grp,
    input logic [PORT_W-1:0]    req_port,
    input logic                 rsp_valid,
    input logic [NUM_PORTS-1:0] rsp_ports,
    input logic                 rsp_drop
);
    logic              acc_q1, acc_q2, grp_q1, grp_q2;
    logic [PORT_W-1:0] ing_q1, ing_q2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q1 <= 1'b0;
            acc_q2 <= 1'b0;
            grp_q1 <= 1'b0;
            grp_q2 <= 1'b0;
            ing_q1 <= '0;
            ing_q2 <= '0;
        end else begin
            acc_q1 <= req_valid && req_ready;
            acc_q2 <= acc_q1;
            grp_q1 <= req_dst_grp;
            grp_q2 <= grp_q1;
            ing_q1 <= req_port;
            ing_q2 <= ing_q1;
        end
    end

    // R1
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == acc_q2);

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_ports == '0 && !rsp_drop));

    // R3
    no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_ports[ing_q2]);

    // R4
    drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_drop) |-> (rsp_ports == '0));

    // R2
    fwd_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_drop) |->
        ($countones(rsp_ports) == 1 || $countones(rsp_ports) == NUM_PORTS - 1));

    // R5
    group_flood_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && grp_q2) |-> (!rsp_drop && $countones(rsp_ports) == NUM_PORTS - 1));
endmodule

bind fwd_engine fwd_engine_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_dst_grp(req_dst[40]),
    .req_port   (req_port),
    .rsp_valid  (rsp_valid),
    .rsp_ports  (rsp_ports),
    .rsp_drop   (rsp_drop)
);

// File: tb/fwd_engine_tb.sv
`timescale 1ns/1ps
module fwd_engine_tb;
    localparam int NP = 4;
    localparam int PW = 2;
    localparam int IW = 4;
    localparam int NB = 16;
    localparam logic [47:0] SALT = 48'h3C5A_9E21_07B4;
    localparam logic [47:0] ADDR_A = 48'h0200_0000_00A1;
    localparam logic [47:0] ADDR_B = 48'h0200_0000_00B2;
    localparam logic [47:0] GRP_D  = 48'h0100_5E00_0001;
    localparam logic [47:0] GRP_P  = 48'h0300_0000_0F0F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [47:0] req_dst = '0;
    logic [47:0] req_src = '0;
    logic [PW-1:0] req_port = '0;
    logic rsp_valid;
    logic [NP-1:0] rsp_ports;
    logic rsp_drop;

    always #10 clk = ~clk;

    fwd_engine #(.NUM_PORTS(NP), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .hash_salt(SALT),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dst(req_dst), .req_src(req_src), .req_port(req_port),
        .rsp_valid(rsp_valid), .rsp_ports(rsp_ports), .rsp_drop(rsp_drop)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic          m_vld [NB][2];
    logic [47:0]   m_mac [NB][2];
    logic [PW-1:0] m_port[NB][2];
    logic          m_last[NB];

    logic [NP-1:0] q_ports[$];
    logic          q_drop[$];
    string         q_tag[$];

    function automatic logic [IW-1:0] bkt_of(input logic [47:0] a);
        logic [47:0] x;
        logic [IW-1:0] r;
        x = a ^ SALT;
        r = '0;
        for (int j = 0; j < 48; j++) r[j % IW] = r[j % IW] ^ x[j];
        return r;
    endfunction

    task automatic model_clear();
        for (int b = 0; b < NB; b++) begin
            m_last[b] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_vld[b][w] = 1'b0; m_mac[b][w] = '0; m_port[b][w] = '0;
            end
        end
    endtask

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [47:0] dst, input logic [47:0] src,
                        input logic [PW-1:0] port, input string tag);
        logic [IW-1:0] b;
        logic hit;
        logic [PW-1:0] eg;
        logic [NP-1:0] fl, ep;
        logic ed;
        string t;
        int v;
        b = bkt_of(dst);
        hit = 1'b0; eg = '0;
        for (int w = 0; w < 2; w++)
            if (m_vld[b][w] && m_mac[b][w] == dst) begin hit = 1'b1; eg = m_port[b][w]; end
        fl = '1; fl[port] = 1'b0;
        ep = '0; ed = 1'b0;
        if (dst[40]) begin ep = fl; t = "R5"; end
        else if (!hit) begin ep = fl; t = "R3"; end
        else if (eg == port) begin ed = 1'b1; t = "R4"; end
        else begin ep[eg] = 1'b1; t = "R2"; end
        if (tag != "") t = tag;
        q_ports.push_back(ep); q_drop.push_back(ed); q_tag.push_back(t);
        // learning, applied after the lookup (R9)
        if (!src[40]) begin
            b = bkt_of(src);
            hit = 1'b0;
            for (int w = 0; w < 2; w++)
                if (m_vld[b][w] && m_mac[b][w] == src) begin hit = 1'b1; m_port[b][w] = port; end
            if (!hit) begin
                if (!m_vld[b][0]) v = 0;
                else if (!m_vld[b][1]) v = 1;
                else v = m_last[b] ? 0 : 1;
                m_vld[b][v] = 1'b1; m_mac[b][v] = src; m_port[b][v] = port;
                m_last[b] = (v == 1);
            end
        end
        req_valid = 1'b1; req_dst = dst; req_src = src; req_port = port;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            if (q_ports.size() == 0) begin
                check(1'b0, "R1", "unexpected response", 64'(rsp_ports), 64'd0);
            end else begin
                logic [NP-1:0] ep;
                logic ed;
                string t;
                ep = q_ports.pop_front(); ed = q_drop.pop_front(); t = q_tag.pop_front();
                check(rsp_ports == ep && rsp_drop == ed, t, "ports/drop",
                      64'({rsp_ports, rsp_drop}), 64'({ep, ed}));
            end
        end
    end

    task automatic drain();
        repeat (4) @(negedge clk);
        check(q_ports.size() == 0, "R1", "missing responses", 64'(q_ports.size()), 64'd0);
        q_ports.delete(); q_drop.delete(); q_tag.delete();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        check(req_ready == 1'b0 && rsp_valid == 1'b0, "R1", "reset outputs",
              64'({req_ready, rsp_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    endtask

    task automatic find_addr(input logic [IW-1:0] b, input logic grp, output logic [47:0] a);
        logic [63:0] r;
        do begin
            r = {$urandom(), $urandom()};
            a = r[47:0];
            a[40] = grp;
        end while (bkt_of(a) != b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog expired: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] x, y, z, g;
        logic [47:0] pool[10];
        logic [IW-1:0] hb;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();

        // directed learning and lookup
        send(ADDR_B, ADDR_A, 2'd1, "R10");   // empty table: flood
        send(ADDR_A, ADDR_B, 2'd2, "R6");    // A learned on port 1
        send(ADDR_B, ADDR_A, 2'd1, "R2");
        send(ADDR_A, GRP_P, 2'd1, "R4");     // A lives on the ingress port
        send(ADDR_A, ADDR_A, 2'd3, "R9");    // sees port 1, then moves A to 3
        send(ADDR_A, ADDR_B, 2'd2, "R6");    // refreshed to port 3
        send(GRP_D, ADDR_B, 2'd0, "R5");
        send(48'hFFFF_FFFF_FFFF, GRP_P, 2'd3, "R5");
        drain();

        // reset empties the table
        do_reset();
        send(ADDR_A, GRP_P, 2'd0, "R10");
        send(ADDR_B, GRP_P, 2'd3, "R10");
        drain();

        // collisions in one bucket
        hb = 4'd9;
        find_addr(hb, 1'b0, x);
        do find_addr(hb, 1'b0, y); while (y == x);
        do find_addr(hb, 1'b0, z); while (z == x || z == y);
        find_addr(hb, 1'b1, g);
        send(GRP_D, x, 2'd0, "R8");
        send(GRP_D, y, 2'd1, "R8");
        send(GRP_D, g, 2'd2, "R7");          // group source must not evict
        send(x, GRP_P, 2'd3, "R7");
        send(y, GRP_P, 2'd3, "R7");
        send(GRP_D, x, 2'd0, "R8");          // refresh x, order unchanged
        send(GRP_D, z, 2'd2, "R8");          // evicts x
        send(x, GRP_P, 2'd3, "R8");
        send(y, GRP_P, 2'd3, "R8");
        send(z, GRP_P, 2'd3, "R8");
        send(z, GRP_P, 2'd2, "R4");
        drain();

        // random traffic over a crowded pool
        do_reset();
        for (int i = 0; i < 10; i++) begin
            if (i < 6) find_addr(4'd5, (i == 5), pool[i]);
            else begin
                r = $urandom();
                find_addr(r[IW-1:0], (i == 9), pool[i]);
            end
        end
        for (int i = 0; i < 600; i++) begin
            logic [47:0] d, s;
            logic [PW-1:0] p;
            r = $urandom(); d = pool[r % 10];
            r = $urandom(); s = pool[r % 10];
            r = $urandom(); p = r[PW-1:0];
            send(d, s, p, "");
            r = $urandom();
            if (r[2:0] == 3'd0) @(negedge clk);
        end
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule